// File: doc/BRIEF.md
# Wait/Hold Programmable Clock Divider

This block derives a slower clock from a domain clock by splitting each output period into a high phase and a low phase. Each phase has its own programmable count. The period spans wait + hold + 2 input cycles. The output is high for wait + 1 cycles and low for hold + 1 cycles. Setting wait to (ratio/2) - 1 and hold to ratio - wait - 2 gives a duty cycle as close to even as the ratio allows.

Software writes one configuration word and sets its apply flag. The flag stays readable as 1 until the divider has adopted the new counts. The divider adopts them only at the end of a whole output period, and the flag clears on that same cycle. A bypass flag routes the input clock directly to the output. Entering or leaving bypass takes place only while the divided output is low, so the switch produces no short pulse. The width of the count fields is a parameter, 3 or 4 bits, which allows ratios from 2 up to 2^(width+1).

Top module: `wh_clock_divider`

## Requirements
- R1: After reset, the configuration word reads as all zeros, and the output divides the input clock by 2: high for 1 cycle, then low for 1 cycle.
- R2: With bypass off, the output is high for wait + 1 input cycles of each period. The wait count is bits [16 +: FW] of the configuration word.
- R3: With bypass off, the output is low for hold + 1 input cycles of each period, so the period is wait + hold + 2 cycles. The hold count is bits [20 +: FW] of the configuration word.
- R4: A write with bit 25 (apply) set makes bit 25 read back as 1 from the next cycle on. Bit 25 clears by itself on the clock edge at which the new counts become active.
- R5: New counts become active only at the end of a complete output period. A period that is already running finishes with the old counts.
- R6: A write with bit 25 clear changes the read-back fields but leaves the output timing and the apply flag unchanged.
- R7: While bit 24 (bypass) is set and active, the output equals the input clock.
- R8: Entering or leaving bypass takes effect only while the divided output is low. A divided high phase in progress when bypass is requested runs to its full length.
- R9: A read returns the programmed wait, hold and bypass fields, together with the live state of the apply flag. All other bits read as zero.
- R10: All-ones fields give the largest ratio, 2^(FW+1). With FW = 4 this is 16 cycles high and 16 cycles low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Domain input clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Configuration word to write |
| rd_data_o | output | 32 | Configuration word read-back, including the live apply flag |
| clk_div_o | output | 1 | Divided clock, or the input clock when in bypass |

## Verification
The bench measures the high and low run lengths of whole output periods for several count pairs: the reset pair (0,0), a near-even pair, a pair with a 1-cycle high phase and a long low phase, a pair with a long high phase and a short low phase, and the all-ones pair. Asymmetric pairs catch a swap of the wait and hold counts and errors of one cycle in either phase. The all-ones pair exposes truncation of the counter width. A write made in the middle of a high phase shows whether the running period finishes with the old counts. A write without the apply flag shows whether the flag alone gates the update. A bypass request made early in a high phase shows whether that phase runs to its full length before the input clock appears at the output.

// File: rtl/wh_div_pkg.sv
// Package: bit positions of the configuration word, shared by the register
// and checker logic. Assumes a 32-bit configuration word.
package wh_div_pkg;
    localparam int CFG_W     = 32;
    localparam int WAIT_LSB  = 16;
    localparam int HOLD_LSB  = 20;
    localparam int BYP_BIT   = 24;
    localparam int APPLY_BIT = 25;
endpackage

// File: rtl/wh_div_cfg.sv
// Module: configuration register. Holds the shadow wait/hold counts and the
// bypass request, plus the pending apply flag. The flag clears when the core
// signals a period boundary. Assumes FW is 3 or 4 so that the fields stay
// inside their 4-bit slots.
module wh_div_cfg
    import wh_div_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             boundary,
    output logic [FW-1:0]    sh_wait,
    output logic [FW-1:0]    sh_hold,
    output logic             byp_req,
    output logic             pending,
    output logic [CFG_W-1:0] rd_data
);
    // Capture the programmed fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_wait <= '0;
            sh_hold <= '0;
            byp_req <= 1'b0;
        end else if (wr_en) begin
            sh_wait <= wr_data[WAIT_LSB +: FW];
            sh_hold <= wr_data[HOLD_LSB +: FW];
            byp_req <= wr_data[BYP_BIT];
        end
    end

    // Apply flag: set by a write, cleared when the core takes the new counts.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (wr_en && wr_data[APPLY_BIT])
            pending <= 1'b1;
        else if (boundary)
            pending <= 1'b0;
    end

    // Read-back word: defined fields only, all other bits zero.
    always_comb begin
        rd_data = '0;
        rd_data[WAIT_LSB +: FW] = sh_wait;
        rd_data[HOLD_LSB +: FW] = sh_hold;
        rd_data[BYP_BIT]        = byp_req;
        rd_data[APPLY_BIT]      = pending;
    end
endmodule

// File: rtl/wh_div_core.sv
// Module: wait/hold counter. The output level is high for act_wait+1 cycles
// and then low for act_hold+1 cycles. At the last low cycle (the boundary) it
// loads the shadow counts if an update is pending. Assumes that a count never
// exceeds 2^FW-1, which the field width guarantees.
module wh_div_core #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [FW-1:0] new_wait,
    input  logic [FW-1:0] new_hold,
    output logic          div_lvl,
    output logic          boundary,
    output logic [FW-1:0] act_wait,
    output logic [FW-1:0] act_hold
);
    localparam int CW = FW;

    logic [CW-1:0] cnt;

    // The end of a period is the last cycle of the low phase.
    assign boundary = !div_lvl && (cnt == act_hold);

    // Phase sequencing and counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lvl <= 1'b0;
            cnt     <= '0;
        end else if (div_lvl) begin
            if (cnt == act_wait) begin
                div_lvl <= 1'b0;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (boundary) begin
            div_lvl <= 1'b1;
            cnt     <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Adopt the new counts only at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_wait <= '0;
            act_hold <= '0;
        end else if (boundary && load_en) begin
            act_wait <= new_wait;
            act_hold <= new_hold;
        end
    end
endmodule

// File: rtl/wh_div_bypass.sv
// Module: bypass selection. The bypass request is taken over only while the
// divided level is low, so the output never shows a short pulse. The output
// then carries either the input clock or the divided level. Assumes that the
// divided level is a registered signal in the clk domain.
module wh_div_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic byp_req,
    input  logic div_lvl,
    output logic byp_act,
    output logic clk_o
);
    // Follow the request only during the divided low phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byp_act <= 1'b0;
        else if (!div_lvl)
            byp_act <= byp_req;
    end

    // Output select.
    assign clk_o = byp_act ? clk : div_lvl;
endmodule

// File: rtl/wh_clock_divider.sv
// Module: top of the wait/hold clock divider. Connects the configuration
// register, the counter core and the bypass select. Assumes FW is 3 or 4 and
// that the write port runs in the clk_i domain.
module wh_clock_divider
    import wh_div_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CFG_W-1:0] rd_data_o,
    output logic             clk_div_o
);
    logic [FW-1:0] sh_wait;
    logic [FW-1:0] sh_hold;
    logic [FW-1:0] act_wait;
    logic [FW-1:0] act_hold;
    logic          byp_req;
    logic          byp_act;
    logic          pending;
    logic          boundary;
    logic          div_lvl;

    wh_div_cfg #(.FW(FW)) u_cfg (
        .clk      (clk_i),
        .rst_n    (rst_n_i),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .boundary (boundary),
        .sh_wait  (sh_wait),
        .sh_hold  (sh_hold),
        .byp_req  (byp_req),
        .pending  (pending),
        .rd_data  (rd_data_o)
    );

    wh_div_core #(.FW(FW)) u_core (
        .clk      (clk_i),
        .rst_n    (rst_n_i),
        .load_en  (pending),
        .new_wait (sh_wait),
        .new_hold (sh_hold),
        .div_lvl  (div_lvl),
        .boundary (boundary),
        .act_wait (act_wait),
        .act_hold (act_hold)
    );

    wh_div_bypass u_byp (
        .clk     (clk_i),
        .rst_n   (rst_n_i),
        .byp_req (byp_req),
        .div_lvl (div_lvl),
        .byp_act (byp_act),
        .clk_o   (clk_div_o)
    );
endmodule

// File: rtl/wh_div_checker.sv
// Module: assertion checker for wh_clock_divider, attached with bind.
// Assumes the signal names inside the top module.
module wh_div_checker
    import wh_div_pkg::*;
#(
    parameter int FW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CFG_W-1:0] wr_data,
    input logic [CFG_W-1:0] rd_data,
    input logic             div_lvl,
    input logic             byp_act,
    input logic             pending,
    input logic [FW-1:0]    act_wait,
    input logic [FW-1:0]    act_hold
);
    // R8: bypass state changes only after a cycle with the divided level low.
    a_r8_bypass_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
        (byp_act != $past(byp_act)) |-> !$past(div_lvl));

    // R4: the apply flag clears only as a new period starts.
    a_r4_apply_clears_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $rose(div_lvl));

    // R5: the active counts change only as a new period starts.
    a_r5_counts_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(div_lvl) |-> ($stable(act_wait) && $stable(act_hold)));

    // R6: a write without the apply flag never raises it.
    a_r6_no_apply_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[APPLY_BIT] && !pending) |=> !pending);

    // R9: bits outside the defined fields read as zero.
    a_r9_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[WAIT_LSB-1:0] == '0) && (rd_data[CFG_W-1:APPLY_BIT+1] == '0));
endmodule

bind wh_clock_divider wh_div_checker #(.FW(FW)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_n_i),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .rd_data  (rd_data_o),
    .div_lvl  (div_lvl),
    .byp_act  (byp_act),
    .pending  (pending),
    .act_wait (act_wait),
    .act_hold (act_hold)
);

// File: tb/tb_wh_clock_divider.sv
`timescale 1ns/1ps
// Bench: the driver pushes expected period shapes into a queue. A monitor
// measures the high and low run lengths at falling clock edges, then pops
// and compares them.
module tb_wh_clock_divider;
    localparam int FW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        clk_div;

    always #2.5 clk = ~clk;

    wh_clock_divider #(.FW(FW)) dut (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .clk_div_o (clk_div)
    );

    typedef struct {
        int    hi;
        int    lo;
        string req;
    } per_t;

    per_t q[$];
    per_t e;
    int   n_checks = 0;
    int   n_fail = 0;
    event rise_ev;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg(input int w, input int h, input bit byp, input bit app);
        logic [31:0] d;
        d = '0;
        d[16 +: FW] = w[FW-1:0];
        d[20 +: FW] = h[FW-1:0];
        d[24] = byp;
        d[25] = app;
        return d;
    endfunction

    // Monitor: measure whole periods and compare them with the queued shapes.
    logic prev_s = 1'b0;
    int   hi_c = 0;
    int   lo_c = 0;
    bit   armed = 1'b0;
    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            prev_s = 1'b0; armed = 1'b0; hi_c = 0; lo_c = 0;
        end else begin
            if (clk_div && !prev_s) begin
                if (armed && q.size() > 0) begin
                    e = q.pop_front();
                    chk(hi_c == e.hi && lo_c == e.lo, e.req, "period hi*1000+lo",
                        hi_c * 1000 + lo_c, e.hi * 1000 + e.lo);
                end
                armed = 1'b1; hi_c = 1; lo_c = 0;
                -> rise_ev;
            end else if (clk_div) begin
                hi_c++;
            end else begin
                lo_c++;
            end
            prev_s = clk_div;
        end
    end

    task automatic wr(input logic [31:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_periods(input int hi, input int lo, input int n, input string req);
        per_t it;
        @(rise_ev);
        for (int i = 0; i < n; i++) begin
            it.hi = hi; it.lo = lo; it.req = req;
            q.push_back(it);
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic wait_applied(input string req);
        int n;
        n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (rd_data[25] && n < 100);
        chk(rd_data[25] == 1'b0, req, "apply flag cleared", rd_data[25], 0);
    endtask

    task automatic run_all();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(rd_data == 32'h0, "R1", "reset read-back", rd_data, 0);
        expect_periods(1, 1, 2, "R1");

        // R4: apply flag visible, then self-clearing
        wr(cfg(3, 2, 0, 1)); #1;
        chk(rd_data[25] == 1'b1, "R4", "apply flag set", rd_data[25], 1);
        wait_applied("R4");
        expect_periods(4, 3, 2, "R2 R3");

        wr(cfg(0, 5, 0, 1)); wait_applied("R4");
        expect_periods(1, 6, 2, "R3");
        wr(cfg(6, 1, 0, 1)); wait_applied("R4");
        expect_periods(7, 2, 2, "R2");

        // R5: update written mid-period takes effect after the period
        wr(cfg(3, 2, 0, 1)); wait_applied("R5");
        @(rise_ev);
        wr(cfg(0, 0, 0, 1));
        begin
            per_t it;
            it.hi = 4; it.lo = 3; it.req = "R5"; q.push_back(it);
            it.hi = 1; it.lo = 1; it.req = "R5"; q.push_back(it);
        end
        while (q.size() > 0) @(negedge clk);

        // R6 / R9: write without apply, undefined bits set in the write
        wr(32'hFC5A_A5A5); #1;
        chk(rd_data == 32'h005A_0000, "R9", "read-back fields", rd_data, 32'h005A_0000);
        chk(rd_data[25] == 1'b0, "R6", "no apply flag", rd_data[25], 0);
        expect_periods(1, 1, 2, "R6");

        // R10: all-ones fields
        wr(cfg(15, 15, 0, 1)); wait_applied("R10");
        expect_periods(16, 16, 1, "R10");

        // R8 / R7: bypass requested early in a high phase
        wr(cfg(3, 2, 0, 1)); wait_applied("R8");
        @(rise_ev);
        wr(cfg(3, 2, 1, 0));
        @(negedge clk); #1;
        chk(clk_div == 1'b1, "R8", "high phase kept", clk_div, 1);
        @(negedge clk); #1;
        chk(clk_div == 1'b1, "R8", "high phase kept", clk_div, 1);
        chk(rd_data[24] == 1'b1, "R9", "bypass read-back", rd_data[24], 1);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            chk(clk_div == 1'b1, "R7", "bypass follows clock high", clk_div, 1);
            @(negedge clk); #1;
            chk(clk_div == 1'b0, "R7", "bypass follows clock low", clk_div, 0);
        end
        wr(cfg(3, 2, 0, 0));
        expect_periods(4, 3, 2, "R8");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule